// File: doc/BRIEF.md
# DMA Loop Address Write-Back Unit

This block works out the addresses a DMA channel descriptor holds after a transfer step, and the byte count its second descriptor word holds. A global mapping enable selects how that word is read. When mapping is off, the whole word is the byte count. When mapping is on, the two top bits are per-direction offset enables. If either enable is set, the word also carries a signed offset that both directions share.

When a minor loop completes, the unit adds the shared offset to the source address, the destination address, or both, as the enables select. When the major loop completes, the offset is not used and each address takes its own last-adjust value. The results are registered. They appear one cycle after the completion strobe, together with a single-cycle valid pulse, so the descriptor store can write them back.

Top module: `dma_loop_addr_upd`

## Requirements
- R1: With `map_en_i` low, `nbytes_o` equals all 32 bits of `word2_i`.
- R2: With `map_en_i` high and bits 31 and 30 of `word2_i` both clear, `nbytes_o` is bits 29:0 zero-extended, and a minor completion leaves both addresses unchanged.
- R3: With `map_en_i` high and bit 31 or bit 30 of `word2_i` set, `nbytes_o` is bits 9:0 zero-extended.
- R4: With mapping on, the offset is bits 29:10 of `word2_i`, sign-extended to 32 bits. On a minor completion it is added to the source address when bit 31 is set and to the destination address when bit 30 is set.
- R5: With `map_en_i` low, a minor completion writes back the input addresses unchanged.
- R6: On a major completion, the source output is `src_addr_i + src_last_i` and the destination output is `dst_addr_i + dst_last_i`. This holds whether or not the minor strobe or the offset enables are also asserted.
- R7: All address sums are 32-bit modulo; a carry out of bit 31 is dropped.
- R8: Updated addresses and `upd_valid_o` appear in the cycle after a strobe. `upd_valid_o` is high for exactly the cycles that follow a strobe, and the address outputs hold their value when no strobe occurred.
- R9: While reset is asserted, all outputs are zero.
- R10: `nbytes_o` is registered every cycle and reflects `word2_i` and `map_en_i` from the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_addr_i | input | 32 | Current source address |
| dst_addr_i | input | 32 | Current destination address |
| word2_i | input | 32 | Byte-count / offset descriptor word |
| map_en_i | input | 1 | Global minor-loop mapping enable |
| src_last_i | input | 32 | Source adjustment at major-loop end |
| dst_last_i | input | 32 | Destination adjustment at major-loop end |
| minor_done_i | input | 1 | Minor loop completed this cycle |
| major_done_i | input | 1 | Major loop completed this cycle |
| src_addr_o | output | 32 | Written-back source address |
| dst_addr_o | output | 32 | Written-back destination address |
| nbytes_o | output | 32 | Decoded minor-loop byte count |
| upd_valid_o | output | 1 | One-cycle write-back strobe |

## Verification
Directed descriptor words cover each combination of mapping enable and offset enables. This separates the 32-bit, 30-bit and 10-bit byte-count views, and shows which address takes the offset. Negative offsets and addresses near the top of the space show sign extension and modulo wrap. A major strobe that arrives with a minor strobe and both enables set shows that the last-adjust values override the offset. Random words, enables and strobe mixes then check every cycle, including idle cycles, against a reference model in the bench. Those checks catch hold and valid-pulse errors.

// File: rtl/dma_loop_pkg.sv
package dma_loop_pkg;
    typedef enum logic [1:0] {
        ADJ_HOLD  = 2'd0,
        ADJ_MINOR = 2'd1,
        ADJ_MAJOR = 2'd2
    } adj_kind_e;

    localparam int DIR_SRC = 0;
    localparam int DIR_DST = 1;
    localparam int NUM_DIR = 2;
endpackage

// File: rtl/dma_w2_decode.sv
module dma_w2_decode #(
    parameter int W2_W       = 32,
    parameter int ADDR_W     = 32,
    parameter int OFF_W      = 20,
    parameter int NB_SHORT_W = 10
) (
    input  logic [W2_W-1:0]   word2_i,
    input  logic              map_en_i,
    output logic [W2_W-1:0]   nbytes_o,
    output logic [ADDR_W-1:0] offset_o,
    output logic              src_off_en_o,
    output logic              dst_off_en_o
);
    localparam int NB_LONG_W = W2_W - 2;
    localparam int OFF_LSB   = NB_SHORT_W;
    localparam int OFF_MSB   = NB_SHORT_W + OFF_W - 1;

    logic [OFF_W-1:0] off_raw;
    logic             any_en;

    always_comb begin
        src_off_en_o = map_en_i & word2_i[W2_W-1];
        dst_off_en_o = map_en_i & word2_i[W2_W-2];
        any_en       = src_off_en_o | dst_off_en_o;
        off_raw      = word2_i[OFF_MSB:OFF_LSB];

        if (!map_en_i) begin
            nbytes_o = word2_i;
        end else if (any_en) begin
            nbytes_o = {{(W2_W-NB_SHORT_W){1'b0}}, word2_i[NB_SHORT_W-1:0]};
        end else begin
            nbytes_o = {2'b00, word2_i[NB_LONG_W-1:0]};
        end

        if (any_en) begin
            offset_o = {{(ADDR_W-OFF_W){off_raw[OFF_W-1]}}, off_raw};
        end else begin
            offset_o = '0;
        end
    end
endmodule

// File: rtl/dma_addr_adjust.sv
module dma_addr_adjust
    import dma_loop_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] last_i,
    input  logic [ADDR_W-1:0] offset_i,
    input  logic              off_en_i,
    input  adj_kind_e         kind_i,
    output logic [ADDR_W-1:0] next_o
);
    logic [ADDR_W-1:0] addend;

    always_comb begin
        unique case (kind_i)
            ADJ_MAJOR: addend = last_i;
            ADJ_MINOR: addend = off_en_i ? offset_i : '0;
            default:   addend = '0;
        endcase
        next_o = addr_i + addend;
    end
endmodule

// File: rtl/dma_loop_addr_upd.sv
module dma_loop_addr_upd
    import dma_loop_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int W2_W       = 32,
    parameter int OFF_W      = 20,
    parameter int NB_SHORT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] src_addr_i,
    input  logic [ADDR_W-1:0] dst_addr_i,
    input  logic [W2_W-1:0]   word2_i,
    input  logic              map_en_i,
    input  logic [ADDR_W-1:0] src_last_i,
    input  logic [ADDR_W-1:0] dst_last_i,
    input  logic              minor_done_i,
    input  logic              major_done_i,
    output logic [ADDR_W-1:0] src_addr_o,
    output logic [ADDR_W-1:0] dst_addr_o,
    output logic [W2_W-1:0]   nbytes_o,
    output logic              upd_valid_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [W2_W-1:0]   nbytes;
        logic              valid;
    } upd_state_t;

    upd_state_t state_d, state_q;

    logic [W2_W-1:0]   dec_nbytes;
    logic [ADDR_W-1:0] dec_offset;
    logic              dec_src_en, dec_dst_en;
    adj_kind_e         kind;

    logic [ADDR_W-1:0] cur_addr [NUM_DIR];
    logic [ADDR_W-1:0] last_adj [NUM_DIR];
    logic              off_en   [NUM_DIR];
    logic [ADDR_W-1:0] next_addr[NUM_DIR];

    dma_w2_decode #(
        .W2_W      (W2_W),
        .ADDR_W    (ADDR_W),
        .OFF_W     (OFF_W),
        .NB_SHORT_W(NB_SHORT_W)
    ) u_dec (
        .word2_i     (word2_i),
        .map_en_i    (map_en_i),
        .nbytes_o    (dec_nbytes),
        .offset_o    (dec_offset),
        .src_off_en_o(dec_src_en),
        .dst_off_en_o(dec_dst_en)
    );

    always_comb begin
        cur_addr[DIR_SRC] = src_addr_i;
        cur_addr[DIR_DST] = dst_addr_i;
        last_adj[DIR_SRC] = src_last_i;
        last_adj[DIR_DST] = dst_last_i;
        off_en[DIR_SRC]   = dec_src_en;
        off_en[DIR_DST]   = dec_dst_en;
        if (major_done_i)      kind = ADJ_MAJOR;
        else if (minor_done_i) kind = ADJ_MINOR;
        else                   kind = ADJ_HOLD;
    end

    for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
        dma_addr_adjust #(
            .ADDR_W(ADDR_W)
        ) u_adj (
            .addr_i  (cur_addr[g]),
            .last_i  (last_adj[g]),
            .offset_i(dec_offset),
            .off_en_i(off_en[g]),
            .kind_i  (kind),
            .next_o  (next_addr[g])
        );
    end

    always_comb begin
        state_d        = state_q;
        state_d.nbytes = dec_nbytes;
        state_d.valid  = (kind != ADJ_HOLD);
        if (kind != ADJ_HOLD) begin
            state_d.src = next_addr[DIR_SRC];
            state_d.dst = next_addr[DIR_DST];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign src_addr_o  = state_q.src;
    assign dst_addr_o  = state_q.dst;
    assign nbytes_o    = state_q.nbytes;
    assign upd_valid_o = state_q.valid;
endmodule

// File: rtl/dma_loop_addr_upd_chk.sv
module dma_loop_addr_upd_chk #(
    parameter int ADDR_W     = 32,
    parameter int W2_W       = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] src_addr_i,
    input logic [ADDR_W-1:0] dst_addr_i,
    input logic [W2_W-1:0]   word2_i,
    input logic              map_en_i,
    input logic [ADDR_W-1:0] src_last_i,
    input logic [ADDR_W-1:0] dst_last_i,
    input logic              minor_done_i,
    input logic              major_done_i,
    input logic [ADDR_W-1:0] src_addr_o,
    input logic [ADDR_W-1:0] dst_addr_o,
    input logic [W2_W-1:0]   nbytes_o,
    input logic              upd_valid_o
);
    AST_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !map_en_i |=> nbytes_o == $past(word2_i)); // R1

    AST_SHORT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (map_en_i && (word2_i[W2_W-1] || word2_i[W2_W-2])) |=> nbytes_o[W2_W-1:10] == '0); // R3

    AST_NO_MAP_NO_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (minor_done_i && !major_done_i && !map_en_i)
        |=> (src_addr_o == $past(src_addr_i)) && (dst_addr_o == $past(dst_addr_i))); // R5

    AST_MAJOR_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        major_done_i |=> (src_addr_o == $past(src_addr_i + src_last_i))
                      && (dst_addr_o == $past(dst_addr_i + dst_last_i))); // R6

    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (minor_done_i || major_done_i) |=> upd_valid_o); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(minor_done_i || major_done_i)
        |=> !upd_valid_o && $stable(src_addr_o) && $stable(dst_addr_o)); // R8
endmodule

bind dma_loop_addr_upd dma_loop_addr_upd_chk #(
    .ADDR_W(ADDR_W),
    .W2_W  (W2_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_addr_i  (src_addr_i),
    .dst_addr_i  (dst_addr_i),
    .word2_i     (word2_i),
    .map_en_i    (map_en_i),
    .src_last_i  (src_last_i),
    .dst_last_i  (dst_last_i),
    .minor_done_i(minor_done_i),
    .major_done_i(major_done_i),
    .src_addr_o  (src_addr_o),
    .dst_addr_o  (dst_addr_o),
    .nbytes_o    (nbytes_o),
    .upd_valid_o (upd_valid_o)
);

// File: tb/dma_loop_addr_upd_bench.sv
`timescale 1ns/1ps
module dma_loop_addr_upd_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_addr_i = '0, dst_addr_i = '0, word2_i = '0;
    logic [31:0] src_last_i = '0, dst_last_i = '0;
    logic        map_en_i = 1'b0, minor_done_i = 1'b0, major_done_i = 1'b0;
    logic [31:0] src_addr_o, dst_addr_o, nbytes_o;
    logic        upd_valid_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] m_src = '0, m_dst = '0;

    always #5 clk = ~clk;

    dma_loop_addr_upd u_dma_loop_addr_upd (
        .clk(clk), .rst_n(rst_n),
        .src_addr_i(src_addr_i), .dst_addr_i(dst_addr_i),
        .word2_i(word2_i), .map_en_i(map_en_i),
        .src_last_i(src_last_i), .dst_last_i(dst_last_i),
        .minor_done_i(minor_done_i), .major_done_i(major_done_i),
        .src_addr_o(src_addr_o), .dst_addr_o(dst_addr_o),
        .nbytes_o(nbytes_o), .upd_valid_o(upd_valid_o)
    );

    function automatic logic [31:0] ref_count(logic [31:0] w, logic m);
        if (!m) return w;
        if (w[31] || w[30]) return {22'd0, w[9:0]};
        return {2'b00, w[29:0]};
    endfunction

    function automatic logic [31:0] ref_off(logic [31:0] w);
        return {{12{w[29]}}, w[29:10]};
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, logic [31:0] sa, logic [31:0] da, logic [31:0] w,
                        logic m, logic [31:0] sl, logic [31:0] dl, logic mi, logic ma);
        @(negedge clk);
        src_addr_i = sa; dst_addr_i = da; word2_i = w; map_en_i = m;
        src_last_i = sl; dst_last_i = dl; minor_done_i = mi; major_done_i = ma;
        if (ma) begin
            m_src = sa + sl;
            m_dst = da + dl;
        end else if (mi) begin
            m_src = sa + ((m && w[31]) ? ref_off(w) : 32'd0);
            m_dst = da + ((m && w[30]) ? ref_off(w) : 32'd0);
        end
        @(posedge clk);
        #1;
        check(tag, "src", src_addr_o, m_src);
        check(tag, "dst", dst_addr_o, m_dst);
        check(tag, "nbytes", nbytes_o, ref_count(w, m));
        check(tag, "valid", {31'd0, upd_valid_o}, {31'd0, (mi | ma)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        check("R9", "src", src_addr_o, 32'd0);
        check("R9", "dst", dst_addr_o, 32'd0);
        check("R9", "nbytes", nbytes_o, 32'd0);
        check("R9", "valid", {31'd0, upd_valid_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R5: mapping off, whole word is count, no offset
        step("R1", 32'h1000, 32'h2000, 32'hC00F_F123, 1'b0, 32'h0, 32'h0, 1'b0, 1'b0);
        step("R5", 32'h1000, 32'h2000, 32'hC00F_F123, 1'b0, 32'h40, 32'h80, 1'b1, 1'b0);
        // R2: mapping on, enables clear
        step("R2", 32'h3000, 32'h4000, 32'h3FFF_FFFF, 1'b1, 32'h0, 32'h0, 1'b1, 1'b0);
        // R3 / R4: source only, negative offset (-4)
        step("R4", 32'h5000, 32'h6000, 32'h8000_0000 | (32'hFFFFC << 10) | 32'h3FF, 1'b1,
             32'h0, 32'h0, 1'b1, 1'b0);
        // R3 / R4: destination only, positive offset 0x10
        step("R3", 32'h5000, 32'h6000, 32'h4000_0000 | (32'h10 << 10) | 32'h020, 1'b1,
             32'h0, 32'h0, 1'b1, 1'b0);
        // R4: both directions share offset
        step("R4", 32'h100, 32'h200, 32'hC000_0000 | (32'h7FFFF << 10) | 32'h001, 1'b1,
             32'h0, 32'h0, 1'b1, 1'b0);
        // R8: idle cycle holds, valid drops
        step("R8", 32'hDEAD_0000, 32'hBEEF_0000, 32'h0, 1'b0, 32'h0, 32'h0, 1'b0, 1'b0);
        // R6: major with minor and both enables set uses last adjusts
        step("R6", 32'h1000, 32'h2000, 32'hC000_0400 | (32'h50 << 10), 1'b1,
             32'hFFFF_FF00, 32'h0000_0100, 1'b1, 1'b1);
        // R7: modulo wrap
        step("R7", 32'hFFFF_FFF0, 32'hFFFF_FFFF, 32'h8000_0000 | (32'h20 << 10), 1'b1,
             32'h0, 32'h0, 1'b1, 1'b0);
        step("R7", 32'hFFFF_FFF0, 32'h8000_0000, 32'h0, 1'b0, 32'h20, 32'h8000_0001, 1'b0, 1'b1);
        // R10: count updates without strobe
        step("R10", 32'h0, 32'h0, 32'h8000_0155, 1'b1, 32'h0, 32'h0, 1'b0, 1'b0);

        // random mix: R4 R6 R8 R10 checked against the model
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r = $urandom;
            step("R4/R6/R8", $urandom, $urandom, $urandom, r[0], $urandom, $urandom,
                 r[1] | r[2], r[3] & r[4]);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule